// File: doc/BRIEF.md
# USB Root-Port Status and Resume Control

This block keeps the status and control state of a single USB 2.0 host root-hub port. Software reads and writes one status word over a simple strobe bus. The physical-layer side reports line events as single-cycle pulses: a J-to-K transition, arrival at high-speed idle, an error found at the end-of-frame check point, a disconnect and a successful enable. A separate level input reports over-current. From these the block keeps the port-enable state, a resume request toward the line driver, a one-cycle pulse toward the global port-change flag, and a watchdog flag for a late return to high-speed idle.

Resume has asymmetric rules. A J-to-K seen during suspend raises the resume bit and pulses the global change output. A software write that raises the same bit does not pulse that output. A software clear is held back: the bit stays at one, and resume stays requested, until the port reports high-speed idle. A counter of `IDLE_LIMIT` clock cycles (2 ms of clock by default) flags a port that does not reach idle in time. Over-current follows its input one cycle late, marks every change in either direction, and holds the port disabled.

Status word layout: bit 0 port enabled (read-only), bit 1 enable change (write-one-to-clear), bit 2 over-current active (read-only), bit 3 over-current change (write-one-to-clear), bit 4 resume (read/write), bit 5 suspended (read-only mirror of the input). All other bits read as zero.

Top module: `usb_port_status`

## Requirements
- R1: After reset is released, every status bit except the suspended mirror reads 0, and resume_req, port_enable, change_pulse and idle_late are 0.
- R2: A phy_jk_seen pulse while port_suspended is 1 and bit 4 is 0 sets bit 4 at the next edge, and change_pulse is 1 for exactly that one cycle. The pulse has no effect when bit 4 is already 1 or the port is not suspended.
- R3: A write with bit 4 = 1 sets bit 4 only while port_suspended is 1, and never raises change_pulse. If it coincides with a qualifying J-to-K pulse, change_pulse is raised.
- R4: resume_req equals bit 4 in every cycle.
- R5: A write with bit 4 = 0 while bit 4 is 1 leaves bit 4 at 1. Bit 4 clears at the edge where phy_hs_idle is sampled high after that write. phy_hs_idle has no effect when no such clear is pending.
- R6: If idle has not arrived, idle_late rises IDLE_LIMIT edges after the edge that registered the clearing write. It stays 0 if idle is sampled at that same edge, and it returns to 0 when idle arrives.
- R7: Bit 2 equals oc_detect as sampled at the previous edge.
- R8: Every change of bit 2, rising or falling, sets bit 3. Writing 1 to bit 3 clears it.
- R9: While oc_detect or bit 2 is 1, port_enable is 0 at the next edge and link_enable is ignored. The over-current disable does not set bit 1.
- R10: link_enable sets port_enable. phy_eof_err clears port_enable and sets bit 1 only if the port was enabled. phy_disconnect clears port_enable without setting bit 1.
- R11: Writing 0 to bit 1 or bit 3 leaves it unchanged. A hardware set and a write-one-to-clear in the same cycle leave the bit at 1.
- R12: Bits 31..6 read as 0 and ignore writes. Writes to bits 0, 2 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Resume-well reset, active low |
| reg_wr | input | 1 | Status word write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Status word read data |
| port_suspended | input | 1 | Port is in suspend |
| phy_jk_seen | input | 1 | J-to-K transition pulse |
| phy_hs_idle | input | 1 | Port reached high-speed idle pulse |
| phy_eof_err | input | 1 | Error at end-of-frame check point pulse |
| phy_disconnect | input | 1 | Disconnect pulse |
| link_enable | input | 1 | Port enabled after reset sequence pulse |
| oc_detect | input | 1 | Over-current condition level |
| resume_req | output | 1 | Drive resume signalling |
| port_enable | output | 1 | Port enabled |
| change_pulse | output | 1 | One-cycle set request for the global change flag |
| idle_late | output | 1 | High-speed idle not reached within the limit |

## Verification
The hardest situation to reach is the exact watchdog boundary. The idle pulse must arrive on precisely the edge where the counter would expire, and the result must be contrasted with one edge later. The bench builds it from a resume raised by software during suspend, a clearing write, and an edge count taken from that write with a small IDLE_LIMIT. Same-cycle collisions, such as a set against a clear or a J-to-K against a software set, are placed in the vector table as single rows.

// File: rtl/usb_ps_pkg.sv
package usb_ps_pkg;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_EN_CHG = 1;
  localparam int unsigned BIT_OC     = 2;
  localparam int unsigned BIT_OC_CHG = 3;
  localparam int unsigned BIT_RESUME = 4;
  localparam int unsigned BIT_SUSP   = 5;
  localparam int unsigned USED_BITS  = 6;

  // write-one-to-clear update, a hardware set dominates
  function automatic logic w1c_next(input logic cur, input logic hw_set, input logic sw_clr);
    return hw_set | (cur & ~sw_clr);
  endfunction

  // watchdog has counted its last cycle
  function automatic logic wd_at_limit(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction
endpackage

// File: rtl/ps_resume_ctl.sv
module ps_resume_ctl #(
  parameter int unsigned IDLE_LIMIT = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspended,
  input  logic jk_seen,
  input  logic hs_idle,
  input  logic sw_wr,
  input  logic sw_val,
  output logic resume_o,
  output logic chg_pulse_o,
  output logic late_o
);
  import usb_ps_pkg::*;
  localparam int unsigned CNT_W = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;

  logic res_q, pend_q, pcd_q, late_q;
  logic [CNT_W-1:0] cnt_q;

  logic hw_set_w, sw_set_w, sw_clr_w, idle_done_w;
  assign hw_set_w    = jk_seen & suspended & ~res_q;
  assign sw_set_w    = sw_wr & sw_val & suspended & ~res_q & ~hw_set_w;
  assign sw_clr_w    = sw_wr & ~sw_val & res_q & ~pend_q;
  assign idle_done_w = hs_idle & pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= 1'b0;
      pend_q <= 1'b0;
      pcd_q  <= 1'b0;
    end else begin
      pcd_q <= hw_set_w;
      if (idle_done_w) begin
        res_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (hw_set_w | sw_set_w) res_q <= 1'b1;
        if (sw_clr_w) pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      late_q <= 1'b0;
    end else if (!pend_q || idle_done_w) begin
      cnt_q  <= '0;
      late_q <= 1'b0;
    end else if (wd_at_limit(32'(cnt_q), IDLE_LIMIT)) begin
      late_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign resume_o    = res_q;
  assign chg_pulse_o = pcd_q;
  assign late_o      = late_q;

  // R2
  pcd_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_q |-> (res_q && !$past(res_q)));
  // R3
  sw_set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_w |=> !pcd_q);
  // R5
  clear_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_q) |-> $past(hs_idle && pend_q));
  // R6
  late_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> (pend_q && res_q));
endmodule

// File: rtl/ps_overcurrent.sv
module ps_overcurrent (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  input  logic chg_clr,
  output logic oc_act_o,
  output logic oc_chg_o
);
  import usb_ps_pkg::*;

  logic act_q, chg_q, edge_w;
  assign edge_w = oc_in ^ act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      act_q <= oc_in;
      chg_q <= w1c_next(chg_q, edge_w, chg_clr);
    end
  end

  assign oc_act_o = act_q;
  assign oc_chg_o = chg_q;

  // R7
  oc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (act_q == $past(oc_in)));
  // R8
  oc_change_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> chg_q);
endmodule

// File: rtl/ps_enable_ctl.sv
module ps_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_hold,
  input  logic eof_err,
  input  logic disconnect,
  input  logic link_up,
  input  logic chg_clr,
  output logic en_o,
  output logic en_chg_o
);
  import usb_ps_pkg::*;

  logic en_q, chg_q, err_dis_w;
  assign err_dis_w = eof_err & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      if (oc_hold | eof_err | disconnect) en_q <= 1'b0;
      else if (link_up)                  en_q <= 1'b1;
      chg_q <= w1c_next(chg_q, err_dis_w, chg_clr);
    end
  end

  assign en_o     = en_q;
  assign en_chg_o = chg_q;

  // R10
  en_chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q) |-> $past(eof_err && en_q));
  // R10
  en_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(link_up && !oc_hold));
endmodule

// File: rtl/usb_port_status.sv
module usb_port_status #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDLE_LIMIT = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              port_suspended,
  input  logic              phy_jk_seen,
  input  logic              phy_hs_idle,
  input  logic              phy_eof_err,
  input  logic              phy_disconnect,
  input  logic              link_enable,
  input  logic              oc_detect,
  output logic              resume_req,
  output logic              port_enable,
  output logic              change_pulse,
  output logic              idle_late
);
  import usb_ps_pkg::*;

  logic oc_act_w, oc_chg_w, en_w, en_chg_w, res_w;
  logic oc_clr_w, en_clr_w;

  assign oc_clr_w = reg_wr & reg_wdata[BIT_OC_CHG];
  assign en_clr_w = reg_wr & reg_wdata[BIT_EN_CHG];

  ps_resume_ctl #(.IDLE_LIMIT(IDLE_LIMIT)) resume_i (
    .clk(clk), .rst_n(rst_n), .suspended(port_suspended),
    .jk_seen(phy_jk_seen), .hs_idle(phy_hs_idle),
    .sw_wr(reg_wr), .sw_val(reg_wdata[BIT_RESUME]),
    .resume_o(res_w), .chg_pulse_o(change_pulse), .late_o(idle_late)
  );

  ps_overcurrent oc_i (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_detect), .chg_clr(oc_clr_w),
    .oc_act_o(oc_act_w), .oc_chg_o(oc_chg_w)
  );

  ps_enable_ctl en_i (
    .clk(clk), .rst_n(rst_n), .oc_hold(oc_detect | oc_act_w),
    .eof_err(phy_eof_err), .disconnect(phy_disconnect), .link_up(link_enable),
    .chg_clr(en_clr_w), .en_o(en_w), .en_chg_o(en_chg_w)
  );

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[BIT_EN]     = en_w;
    reg_rdata[BIT_EN_CHG] = en_chg_w;
    reg_rdata[BIT_OC]     = oc_act_w;
    reg_rdata[BIT_OC_CHG] = oc_chg_w;
    reg_rdata[BIT_RESUME] = res_w;
    reg_rdata[BIT_SUSP]   = port_suspended;
  end

  assign resume_req  = res_w;
  assign port_enable = en_w;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[DATA_W-1:USED_BITS], reg_wdata[BIT_SUSP],
                          reg_wdata[BIT_OC], reg_wdata[BIT_EN]};

  // R9
  oc_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_act_w |-> !en_w);
  // R4
  resume_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req == reg_rdata[BIT_RESUME]);
endmodule

// File: tb/usb_port_status_tb_top.sv
module usb_port_status_tb_top;
  localparam int unsigned WD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic susp = 1'b0, jk = 1'b0, idle = 1'b0, eof = 1'b0, disc = 1'b0, lnk = 1'b0, oc = 1'b0;
  logic resume_req, port_enable, change_pulse, idle_late;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  usb_port_status #(.DATA_W(32), .IDLE_LIMIT(WD)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_suspended(susp), .phy_jk_seen(jk),
    .phy_hs_idle(idle), .phy_eof_err(eof), .phy_disconnect(disc),
    .link_enable(lnk), .oc_detect(oc), .resume_req(resume_req),
    .port_enable(port_enable), .change_pulse(change_pulse), .idle_late(idle_late)
  );

  // fields: wr, wdata[5:0], susp jk idle eof disc lnk oc, expected rd[5:0], expected pulse
  typedef struct packed {
    logic       wr;
    logic [5:0] wd;
    logic [6:0] ev;
    logic [5:0] rd;
    logic       pcd;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    21'b0_000000_0000010_000001_0, // 0  R10 enable
    21'b0_000000_0001000_000010_0, // 1  R10 eof error disables
    21'b1_000000_0000000_000010_0, // 2  R11 write zero
    21'b1_000010_0000000_000000_0, // 3  R11 write one clears
    21'b0_000000_0000010_000001_0, // 4  R10
    21'b0_000000_0000100_000000_0, // 5  R10 disconnect, no change
    21'b0_000000_0000010_000001_0, // 6  R10
    21'b0_000000_0000001_001100_0, // 7  R9 over-current
    21'b0_000000_0000011_001100_0, // 8  R9 enable ignored
    21'b1_001000_0000001_000100_0, // 9  R8 clear
    21'b0_000000_0000000_001000_0, // 10 R7 falling marks change
    21'b1_001000_0000000_000000_0, // 11 R8
    21'b1_001000_0000001_001100_0, // 12 R11 set wins
    21'b1_001000_0000001_000100_0, // 13 R8
    21'b0_000000_0000000_001000_0, // 14 R7
    21'b1_001000_0000000_000000_0, // 15 R8
    21'b1_010000_0000000_000000_0, // 16 R3 not suspended
    21'b0_000000_1000000_100000_0, // 17 R12 mirror
    21'b0_000000_1100000_110000_1, // 18 R2 hw resume
    21'b0_000000_1000000_110000_0, // 19 R2 single pulse
    21'b1_000000_1000000_110000_0, // 20 R5 clear held
    21'b0_000000_1000000_110000_0, // 21 R5
    21'b0_000000_1010000_100000_0, // 22 R5 idle clears
    21'b1_010000_1000000_110000_0, // 23 R3 sw set quiet
    21'b0_000000_1100000_110000_0, // 24 R2 already set
    21'b1_000000_1000000_110000_0, // 25 R5
    21'b0_000000_1010000_100000_0, // 26 R5
    21'b0_000000_0010000_000000_0, // 27 R5 idle no pending
    21'b0_000000_0100000_000000_0, // 28 R2 not suspended
    21'b1_100101_0000000_000000_0, // 29 R12 read-only writes
    21'b0_000000_0000010_000001_0, // 30 R10
    21'b1_000010_0001000_000010_0, // 31 R11 set wins
    21'b1_000010_0000000_000000_0, // 32 R11
    21'b0_000000_0001000_000000_0, // 33 R10 eof while disabled
    21'b1_010000_1100000_110000_1, // 34 R3 jk with sw set
    21'b1_000000_1000000_110000_0, // 35 R5
    21'b0_000000_1010000_100000_0  // 36 R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    reg_wr = v.wr;
    reg_wdata = {26'd0, v.wd};
    {susp, jk, idle, eof, disc, lnk, oc} = v.ev;
  endtask

  task automatic quiet();
    reg_wr = 1'b0; reg_wdata = '0;
    jk = 1'b0; idle = 1'b0; eof = 1'b0; disc = 1'b0; lnk = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 outputs", {28'd0, resume_req, port_enable, change_pulse, idle_late}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1;
      check($sformatf("vector %0d rdata", i), reg_rdata, {26'd0, VECS[i].rd});
      check($sformatf("vector %0d R2 change_pulse", i), {31'd0, change_pulse}, {31'd0, VECS[i].pcd});
      check($sformatf("vector %0d R4 resume_req", i), {31'd0, resume_req}, {31'd0, VECS[i].rd[4]});
    end
    @(negedge clk);
    quiet(); susp = 1'b0; oc = 1'b0;

    // R12: upper bits ignore writes and read zero
    reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFC0;
    @(negedge clk);
    quiet();
    check("R12 upper bits", reg_rdata, 32'h0);

    // R6: watchdog expires one edge after the limit window
    susp = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h10;
    @(negedge clk);
    reg_wdata = 32'h0;
    @(negedge clk);
    quiet();
    repeat (WD - 1) @(negedge clk);
    check("R6 not yet late", {31'd0, idle_late}, 32'h0);
    @(negedge clk);
    check("R6 late", {31'd0, idle_late}, 32'h1);
    check("R5 still resuming", {31'd0, resume_req}, 32'h1);
    idle = 1'b1;
    @(negedge clk);
    quiet();
    check("R6 late cleared", {31'd0, idle_late}, 32'h0);
    check("R5 resume cleared", {31'd0, resume_req}, 32'h0);

    // R6: idle arriving exactly at the limit edge
    reg_wr = 1'b1; reg_wdata = 32'h10;
    @(negedge clk);
    reg_wdata = 32'h0;
    @(negedge clk);
    quiet();
    repeat (WD - 1) @(negedge clk);
    idle = 1'b1;
    @(negedge clk);
    quiet();
    check("R6 boundary no late", {31'd0, idle_late}, 32'h0);
    check("R5 boundary cleared", {31'd0, resume_req}, 32'h0);

    // R1: reset in the middle of activity
    lnk = 1'b1; jk = 1'b1;
    @(negedge clk);
    quiet(); oc = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; oc = 1'b0; susp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", reg_rdata, 32'h0);
    check("R1 reset outputs", {28'd0, resume_req, port_enable, change_pulse, idle_late}, 32'h0);

    summary();
  end
endmodule